// File: doc/BRIEF.md
# HDLC Frame Transmitter with Alternating Message Buffers

This block sends bit-oriented HDLC frames on a serial data link. A host fills one of two message buffers through a small write port: first a length word, which also carries an end-of-message marker, then the payload bytes at consecutive addresses. It then sets that buffer's send request. The transmitter wraps the payload in opening and closing 0x7E flags, appends a 16-bit frame check sequence, inserts a zero after every run of five ones, and shifts out one line bit for each data-link enable strobe.

Long messages are streamed in chunks. When a buffer ends without the end-of-message marker and the other buffer is already requested, the frame carries on from the other buffer with no flag in between. Each time a buffer is taken for sending, a one-cycle start-of-transmission pulse names it, and the host may then fill the other buffer. If the host is too late, the frame is aborted with eight ones. Between frames the line carries back-to-back flags.

Top module: `hdlc_pp_tx`

## Requirements
- R1: After reset `tx_bit` is 1. With no buffer requested, the bits sent on successive strobes are continuous 0x7E flag bytes, least significant bit first.
- R2: A length write (`host_cnt_sel`=1) sets the selected buffer's byte count (values above the capacity are clamped) and its end-of-message marker from `host_eom`, and returns that buffer's write address to 0. A data write (`host_cnt_sel`=0) stores a byte at the current address and advances it, so a length rewrite discards earlier data writes.
- R3: A buffer is never sent before its send request (`host_go` with `host_buf`). A requested buffer is taken only at a flag byte boundary, so a complete flag always precedes the first payload bit.
- R4: Taking a buffer raises `sot` for exactly one clock, in the cycle after the strobe that takes it, with `sot_buf` naming the buffer.
- R5: Payload bytes go out in write order, each least significant bit first. The received frame carries exactly the written bytes.
- R6: Inside payload and check sequence, a 0 is inserted after every five consecutive 1s, including just before the closing flag or an abort.
- R7: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, preset to all ones and computed LSB first over the payload. It is sent complemented, low byte first. A receiver running the same CRC over payload and check sequence ends with 0xF0B8.
- R8: A buffer whose end-of-message marker is set is followed by the check sequence and a closing flag, which completes exactly one frame.
- R9: If a buffer without end-of-message runs out while the other buffer is requested, the frame continues from that buffer with no flag in between. Buffers are always taken in alternating order 0, 1, 0, ...
- R10: If a buffer without end-of-message runs out while the other buffer is not requested, eight 1s are sent in place of a check sequence, followed by flags. No frame is completed.
- R11: `tx_bit` changes only on the clock edge at which `dl_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_cnt_sel | input | 1 | 1: write byte count and end marker; 0: write payload byte |
| host_buf | input | 1 | Buffer selected for a write or send request |
| host_wdata | input | 8 | Byte count or payload byte |
| host_eom | input | 1 | End-of-message marker, captured on a count write |
| host_go | input | 1 | Send request for buffer `host_buf` |
| dl_en | input | 1 | Data-link bit strobe: one line bit per high cycle |
| tx_bit | output | 1 | Serial line bit |
| sot | output | 1 | Start-of-transmission pulse |
| sot_buf | output | 1 | Buffer taken when `sot` is high |

## Verification
Single-chunk frames are sent with spread byte values, all-ones bytes, bytes equal to the flag, alternating 0xF8/0x1F bytes and all-zero bytes. These patterns separate correct zero insertion (runs within a byte, across a byte boundary, and next to the check sequence) from flag imitation in the payload, and a wrong CRC bit order from a right one. Lengths of 1 and of the full 96 bytes, and strobe gaps from none to five idle cycles, show that buffer bounds and bit pacing hold. Directed cases cover a 150-byte message split over both buffers, a missing second chunk that must abort, a length rewrite that drops stale data, and a loaded buffer with no send request.

// File: rtl/hdlc_pp_pkg.sv
package hdlc_pp_pkg;

   typedef enum logic [1:0] {
      TXM_FLAG  = 2'd0,
      TXM_DATA  = 2'd1,
      TXM_FCS   = 2'd2,
      TXM_ABORT = 2'd3
   } txm_e;

   localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
   localparam logic [7:0]  ABORT_BYTE = 8'hFF;
   localparam logic [15:0] CRC_PRESET = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_R = 16'h8408;

   // one serial CRC step, LSB-first (reflected) form
   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[0] ^ b;
      return (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
   endfunction

endpackage

// File: rtl/hdlc_pp_bufs.sv
module hdlc_pp_bufs #(
   parameter int MAX_BYTES = 96,
   parameter int CNT_W     = 7,
   parameter int AW        = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic                  cnt_sel,
   input  logic                  wbuf,
   input  logic [7:0]            wdata,
   input  logic                  weom,
   input  logic                  go,
   input  logic                  take,
   input  logic                  take_buf,
   input  logic                  rd_buf,
   input  logic [AW-1:0]         rd_addr,
   output logic [7:0]            rd_data,
   output logic [1:0][CNT_W-1:0] cnt,
   output logic [1:0]            eom,
   output logic [1:0]            rdy
);
   localparam int               DEPTH = 1 << AW;
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BYTES);
   localparam logic [7:0]       MAX_B = 8'(MAX_BYTES);

   logic [7:0]       bdata [2];
   logic [CNT_W-1:0] cw;

   assign cw = (wdata > MAX_B) ? MAX_C : CNT_W'(wdata);

   for (genvar g = 0; g < 2; g++) begin : g_buf
      logic [7:0]       mem [DEPTH];
      logic [CNT_W-1:0] wp_q;
      logic [CNT_W-1:0] cnt_q;
      logic             eom_q;
      logic             rdy_q;
      logic             sel;

      assign sel = (wbuf == 1'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            cnt_q <= '0;
            eom_q <= 1'b0;
            rdy_q <= 1'b0;
         end else begin
            if (wr && sel) begin
               if (cnt_sel) begin
                  cnt_q <= cw;
                  eom_q <= weom;
                  wp_q  <= '0;
               end else if (wp_q < MAX_C) begin
                  wp_q <= wp_q + CNT_W'(1);
               end
            end
            if (go && sel)
               rdy_q <= 1'b1;
            else if (take && (take_buf == 1'(g)))
               rdy_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr && sel && !cnt_sel && (wp_q < MAX_C))
            mem[wp_q[AW-1:0]] <= wdata;
      end

      assign bdata[g] = mem[rd_addr];
      assign cnt[g]   = cnt_q;
      assign eom[g]   = eom_q;
      assign rdy[g]   = rdy_q;
   end

   assign rd_data = bdata[rd_buf];

endmodule

// File: rtl/hdlc_pp_ser.sv
module hdlc_pp_ser
   import hdlc_pp_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int AW    = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dl_en,
   input  logic [1:0]            rdy,
   input  logic [1:0][CNT_W-1:0] cnt,
   input  logic [1:0]            eom,
   input  logic [7:0]            rd_data,
   output logic                  rd_buf,
   output logic [AW-1:0]         rd_addr,
   output logic                  take,
   output logic                  take_buf,
   output logic                  tx_bit,
   output logic                  sot,
   output logic                  sot_buf
);
   txm_e             mode_q;
   logic [7:0]       sh_q;
   logic [2:0]       bitc_q;
   logic [2:0]       ones_q;
   logic [15:0]      crc_q;
   logic             cur_q;
   logic [CNT_W-1:0] ptr_q;
   logic             fcs_hi_q;

   logic        stuff, byte_end, drained;
   logic [15:0] crc_nx;

   always_comb begin
      stuff    = (ones_q == 3'd5);
      byte_end = !stuff && (bitc_q == 3'd7);
      drained  = (ptr_q >= cnt[cur_q]);
      crc_nx   = crc_step(crc_q, sh_q[0]);
      take_buf = (mode_q == TXM_DATA) ? !cur_q : cur_q;
      take     = dl_en && byte_end &&
                 (((mode_q == TXM_FLAG) && rdy[cur_q]) ||
                  ((mode_q == TXM_DATA) && drained && !eom[cur_q] && rdy[!cur_q]));
      if ((mode_q == TXM_DATA) && drained) begin
         rd_buf  = !cur_q;
         rd_addr = '0;
      end else begin
         rd_buf  = cur_q;
         rd_addr = (mode_q == TXM_DATA) ? ptr_q[AW-1:0] : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= TXM_FLAG;
         sh_q     <= FLAG_BYTE;
         bitc_q   <= '0;
         ones_q   <= '0;
         crc_q    <= CRC_PRESET;
         cur_q    <= 1'b0;
         ptr_q    <= '0;
         fcs_hi_q <= 1'b0;
         tx_bit   <= 1'b1;
         sot      <= 1'b0;
         sot_buf  <= 1'b0;
      end else begin
         sot <= 1'b0;
         if (dl_en) begin
            if (take) begin
               sot     <= 1'b1;
               sot_buf <= take_buf;
            end
            if (stuff) begin
               tx_bit <= 1'b0;
               ones_q <= '0;
            end else begin
               tx_bit <= sh_q[0];
               if ((mode_q == TXM_DATA) || (mode_q == TXM_FCS))
                  ones_q <= sh_q[0] ? ones_q + 3'd1 : 3'd0;
               else
                  ones_q <= '0;
               if (mode_q == TXM_DATA)
                  crc_q <= crc_nx;
               if (!byte_end) begin
                  sh_q   <= sh_q >> 1;
                  bitc_q <= bitc_q + 3'd1;
               end else begin
                  bitc_q <= '0;
                  unique case (mode_q)
                     TXM_FLAG: begin
                        if (rdy[cur_q]) begin
                           sh_q   <= rd_data;
                           mode_q <= TXM_DATA;
                           ptr_q  <= CNT_W'(1);
                           crc_q  <= CRC_PRESET;
                        end else begin
                           sh_q <= FLAG_BYTE;
                        end
                     end
                     TXM_ABORT: begin
                        sh_q   <= FLAG_BYTE;
                        mode_q <= TXM_FLAG;
                     end
                     TXM_DATA: begin
                        if (!drained) begin
                           sh_q  <= rd_data;
                           ptr_q <= ptr_q + CNT_W'(1);
                        end else begin
                           cur_q <= !cur_q;
                           if (eom[cur_q]) begin
                              sh_q     <= ~crc_nx[7:0];
                              mode_q   <= TXM_FCS;
                              fcs_hi_q <= 1'b0;
                           end else if (rdy[!cur_q]) begin
                              sh_q  <= rd_data;
                              ptr_q <= CNT_W'(1);
                           end else begin
                              sh_q   <= ABORT_BYTE;
                              mode_q <= TXM_ABORT;
                           end
                        end
                     end
                     TXM_FCS: begin
                        if (!fcs_hi_q) begin
                           sh_q     <= ~crc_q[15:8];
                           fcs_hi_q <= 1'b1;
                        end else begin
                           sh_q   <= FLAG_BYTE;
                           mode_q <= TXM_FLAG;
                        end
                     end
                     default: ;
                  endcase
               end
            end
         end
      end
   end

endmodule

// File: rtl/hdlc_pp_tx.sv
module hdlc_pp_tx #(
   parameter int MAX_BYTES = 96
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic       host_cnt_sel,
   input  logic       host_buf,
   input  logic [7:0] host_wdata,
   input  logic       host_eom,
   input  logic       host_go,
   input  logic       dl_en,
   output logic       tx_bit,
   output logic       sot,
   output logic       sot_buf
);
   localparam int CNT_W = $clog2(MAX_BYTES + 1);
   localparam int AW    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

   if (MAX_BYTES < 1 || MAX_BYTES > 255) begin : g_bad_max_bytes
      $error("MAX_BYTES must lie in 1..255");
   end

   logic                  take, take_buf, rd_buf;
   logic [AW-1:0]         rd_addr;
   logic [7:0]            rd_data;
   logic [1:0][CNT_W-1:0] cnt;
   logic [1:0]            eom, rdy;

   hdlc_pp_bufs #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .AW(AW)) u_bufs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (host_wr),
      .cnt_sel  (host_cnt_sel),
      .wbuf     (host_buf),
      .wdata    (host_wdata),
      .weom     (host_eom),
      .go       (host_go),
      .take     (take),
      .take_buf (take_buf),
      .rd_buf   (rd_buf),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .cnt      (cnt),
      .eom      (eom),
      .rdy      (rdy)
   );

   hdlc_pp_ser #(.CNT_W(CNT_W), .AW(AW)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .dl_en    (dl_en),
      .rdy      (rdy),
      .cnt      (cnt),
      .eom      (eom),
      .rd_data  (rd_data),
      .rd_buf   (rd_buf),
      .rd_addr  (rd_addr),
      .take     (take),
      .take_buf (take_buf),
      .tx_bit   (tx_bit),
      .sot      (sot),
      .sot_buf  (sot_buf)
   );

endmodule

// File: rtl/hdlc_pp_tx_chk.sv
module hdlc_pp_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dl_en,
   input logic       tx_bit,
   input logic       sot,
   input logic       sot_buf,
   input logic       take,
   input logic       take_buf,
   input logic [1:0] rdy
);
   logic last_buf_q, have_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_buf_q  <= 1'b0;
         have_last_q <= 1'b0;
      end else if (sot) begin
         last_buf_q  <= sot_buf;
         have_last_q <= 1'b1;
      end
   end

   a_r11_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !dl_en |=> $stable(tx_bit));

   a_r4_sot_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      sot |=> !sot);

   a_r4_sot_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sot |-> $past(dl_en));

   a_r3_take_only_requested: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> rdy[take_buf]);

   a_r9_buffers_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      (sot && have_last_q) |-> (sot_buf != last_buf_q));

endmodule

bind hdlc_pp_tx hdlc_pp_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dl_en    (dl_en),
   .tx_bit   (tx_bit),
   .sot      (sot),
   .sot_buf  (sot_buf),
   .take     (take),
   .take_buf (take_buf),
   .rdy      (rdy)
);

// File: tb/hdlc_pp_tx_test.sv
module hdlc_pp_tx_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAXB       = 96;
   localparam int NVEC       = 6;
   // {length, pattern, seed, strobe gap}
   localparam logic [31:0] VEC [NVEC] = '{
      {8'd12, 8'd0, 8'd3,  8'd0},
      {8'd1,  8'd1, 8'd0,  8'd2},
      {8'd96, 8'd0, 8'd91, 8'd1},
      {8'd20, 8'd2, 8'd0,  8'd3},
      {8'd33, 8'd3, 8'd0,  8'd0},
      {8'd2,  8'd4, 8'd0,  8'd5}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_cnt_sel = 1'b0, host_buf = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic       host_eom = 1'b0, host_go = 1'b0;
   logic       dl_en = 1'b0;
   logic       tx_bit, sot, sot_buf;

   hdlc_pp_tx #(.MAX_BYTES(MAXB)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_cnt_sel(host_cnt_sel),
      .host_buf(host_buf), .host_wdata(host_wdata), .host_eom(host_eom),
      .host_go(host_go), .dl_en(dl_en), .tx_bit(tx_bit), .sot(sot), .sot_buf(sot_buf)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;

   // receiver model state
   logic       bitbuf [4096];
   int         nbits = 0, r_ones = 0;
   bit         in_frame = 0;
   int         frame_cnt = 0, abort_cnt = 0, flag_cnt = 0;
   int         rx_len = 0;
   bit         rx_ok = 0;
   logic [7:0] rx_byte [512];
   logic [7:0] exp_src [512];
   logic       sot_log [64];
   int         sot_n = 0;
   int         hold_viol = 0;
   logic       prev_tx = 1'b1;
   logic       took = 1'b0;
   bit         run_en = 0;
   int         gap = 0, gcnt = 0;
   logic       nxt_b = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic deliver(input int nb);
      logic [15:0] c;
      if (nb == 0) return;
      frame_cnt++;
      c = 16'hFFFF;
      for (int i = 0; i < nb; i++) begin
         logic fb;
         fb = c[0] ^ bitbuf[i];
         c  = c >> 1;
         if (fb) c = c ^ 16'h8408;
      end
      rx_ok  = (nb % 8 == 0) && (nb >= 24) && (c == 16'hF0B8);
      rx_len = nb / 8 - 2;
      for (int k = 0; k < nb / 8 && k < 512; k++)
         for (int j = 0; j < 8; j++)
            rx_byte[k][j] = bitbuf[k * 8 + j];
   endtask

   task automatic rx_bit(input logic b);
      if (b) begin
         r_ones++;
         if (r_ones == 7) begin
            abort_cnt++;
            in_frame = 0;
         end
         if (in_frame && r_ones < 7 && nbits < 4096) begin
            bitbuf[nbits] = 1'b1;
            nbits++;
         end
      end else begin
         if (r_ones == 6) begin
            flag_cnt++;
            if (in_frame && nbits >= 7) deliver(nbits - 7);
            in_frame = 1;
            nbits    = 0;
         end else if (r_ones < 5) begin
            if (in_frame && nbits < 4096) begin
               bitbuf[nbits] = 1'b0;
               nbits++;
            end
         end
         r_ones = 0;
      end
   endtask

   always @(posedge clk) took <= dl_en;

   always @(negedge clk) begin
      if (rst_n) begin
         if (took) rx_bit(tx_bit);
         else if (tx_bit !== prev_tx) hold_viol++;
         prev_tx = tx_bit;
         if (sot && sot_n < 64) begin
            sot_log[sot_n] = sot_buf;
            sot_n++;
         end
         if (run_en) begin
            if (gcnt >= gap) begin
               dl_en = 1'b1;
               gcnt  = 0;
            end else begin
               dl_en = 1'b0;
               gcnt++;
            end
         end else begin
            dl_en = 1'b0;
         end
      end
   end

   function automatic logic [7:0] pat_byte(input int pat, input int seed, input int i);
      case (pat)
         0:       return 8'(i * 37 + seed * 11 + 5);
         1:       return 8'hFF;
         2:       return 8'h7E;
         3:       return i[0] ? 8'h1F : 8'hF8;
         default: return 8'h00;
      endcase
   endfunction

   task automatic hw(input logic csel, input logic b, input logic [7:0] d, input logic e);
      @(negedge clk);
      host_wr = 1'b1; host_cnt_sel = csel; host_buf = b; host_wdata = d; host_eom = e;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic load(input logic b, input int off, input int n, input logic e);
      hw(1'b1, b, 8'(n), e);
      for (int i = 0; i < n; i++) hw(1'b0, b, exp_src[off + i], 1'b0);
   endtask

   task automatic go(input logic b);
      @(negedge clk);
      host_go = 1'b1; host_buf = b;
      @(negedge clk);
      host_go = 1'b0;
   endtask

   task automatic wait_frames(input int target);
      for (int i = 0; i < 30000 && frame_cnt < target; i++) @(negedge clk);
   endtask

   task automatic wait_sots(input int target);
      for (int i = 0; i < 30000 && sot_n < target; i++) @(negedge clk);
   endtask

   task automatic check_frame(input int len, input string tag);
      int bad;
      bad = 0;
      chk(rx_len == len, {tag, " R5 length"}, rx_len, len);
      for (int i = 0; i < len; i++) if (rx_byte[i] !== exp_src[i]) bad++;
      chk(bad == 0, {tag, " R5 payload bytes"}, bad, 0);
      chk(rx_ok, {tag, " R7 crc residue"}, int'(rx_ok), 1);
   endtask

   task automatic send_frame(input int len, input int pat, input int seed, input int gp);
      int fc0, s0;
      gap = gp;
      for (int i = 0; i < len; i++) exp_src[i] = pat_byte(pat, seed, i);
      fc0 = frame_cnt; s0 = sot_n;
      load(nxt_b, 0, len, 1'b1);
      go(nxt_b);
      wait_frames(fc0 + 1);
      chk(frame_cnt == fc0 + 1, "R8 one frame per buffer", frame_cnt - fc0, 1);
      chk(sot_n == s0 + 1 && sot_log[s0] == nxt_b, "R4 sot names buffer",
          int'(sot_log[s0]), int'(nxt_b));
      check_frame(len, (pat == 1 || pat == 3) ? "R6 stuffing" : "vector");
      nxt_b = !nxt_b;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int fc0, s0, a0, f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(tx_bit == 1'b1, "R1 tx_bit after reset", int'(tx_bit), 1);
      chk(sot == 1'b0, "R4 sot idle after reset", int'(sot), 0);

      // R1: idle flags
      run_en = 1;
      repeat (200) @(negedge clk);
      chk(flag_cnt >= 20, "R1 idle flags", flag_cnt, 20);
      chk(frame_cnt == 0 && abort_cnt == 0, "R1 no frame while idle", frame_cnt + abort_cnt, 0);

      // vector table
      for (int v = 0; v < NVEC; v++)
         send_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));

      // R3: loaded but not requested
      gap = 0;
      for (int i = 0; i < 5; i++) exp_src[i] = 8'(8'h30 + i);
      fc0 = frame_cnt; s0 = sot_n;
      load(nxt_b, 0, 5, 1'b1);
      repeat (400) @(negedge clk);
      chk(sot_n == s0, "R3 no take without request", sot_n - s0, 0);
      chk(frame_cnt == fc0, "R3 no frame without request", frame_cnt - fc0, 0);
      go(nxt_b);
      wait_frames(fc0 + 1);
      chk(frame_cnt == fc0 + 1, "R3 frame after request", frame_cnt - fc0, 1);
      check_frame(5, "R3");
      nxt_b = !nxt_b;

      // R2: count rewrite returns pointer to 0
      for (int i = 0; i < 4; i++) exp_src[i] = 8'(8'hC1 + 3 * i);
      fc0 = frame_cnt;
      hw(1'b1, nxt_b, 8'd4, 1'b1);
      for (int i = 0; i < 3; i++) hw(1'b0, nxt_b, 8'hAA, 1'b0);
      load(nxt_b, 0, 4, 1'b1);
      go(nxt_b);
      wait_frames(fc0 + 1);
      check_frame(4, "R2 pointer reset");
      nxt_b = !nxt_b;

      // R9: 150 byte message in two chunks
      gap = 1;
      for (int i = 0; i < 150; i++) exp_src[i] = 8'(i * 13 + 7);
      fc0 = frame_cnt; s0 = sot_n; f0 = flag_cnt;
      load(nxt_b, 0, 96, 1'b0);
      go(nxt_b);
      wait_sots(s0 + 1);
      load(!nxt_b, 96, 54, 1'b1);
      go(!nxt_b);
      wait_frames(fc0 + 1);
      chk(frame_cnt == fc0 + 1, "R9 one frame over two chunks", frame_cnt - fc0, 1);
      check_frame(150, "R9 chained");
      chk(sot_n == s0 + 2, "R9 two sot pulses", sot_n - s0, 2);
      chk(sot_log[s0] == nxt_b && sot_log[s0 + 1] == !nxt_b, "R9 sot order",
          int'(sot_log[s0 + 1]), int'(!nxt_b));

      // R10: second chunk missing -> abort (nxt_b unchanged after two buffers)
      gap = 0;
      for (int i = 0; i < 6; i++) exp_src[i] = 8'(8'h55 + i);
      fc0 = frame_cnt; a0 = abort_cnt;
      load(nxt_b, 0, 6, 1'b0);
      go(nxt_b);
      for (int i = 0; i < 2000 && abort_cnt == a0; i++) @(negedge clk);
      repeat (50) @(negedge clk);
      chk(abort_cnt == a0 + 1, "R10 abort sent", abort_cnt - a0, 1);
      chk(frame_cnt == fc0, "R10 no frame after abort", frame_cnt - fc0, 0);
      nxt_b = !nxt_b;

      // recovery after abort
      send_frame(7, 0, 42, 2);

      // R11: line bit held between strobes
      chk(hold_viol == 0, "R11 tx_bit only moves on strobe", hold_viol, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule